// File: doc/BRIEF.md
# Attribute Colour Mapper with Split-Screen Panning Override

This block sits between the pixel fetch path and the colour lookup table of a display controller. For every pixel attribute it receives, it forms an 8-bit colour-table address. It can take that address from a 16-entry internal palette combined with a colour-select register, or it can pass the attribute straight through. It also reports the horizontal fine-panning value that the downstream pixel shifter should apply.

Software reaches the registers through one shared write port. An internal phase flip-flop decides whether each write is taken as a register index or as data. A strobe input, driven when software reads the display status, returns the flip-flop to the index phase.

The CRT timing logic supplies two strobes. A line-compare hit starts a split-screen region in which the panning output is held at zero, if the compatibility bit is set. The vertical-sync strobe ends that region.

Pixels arrive on a valid/ready stream and leave on a second valid/ready stream with one register stage between them. A pixel is accepted when `pix_valid` and `pix_ready` are both high. `pix_ready` is high whenever the output stage is empty or `dac_ready` is high. While `dac_valid` is high and `dac_ready` is low, the output address is held unchanged.

Top module: `attr_lut_path`

## Requirements
- R1: After reset the outputs are as follows: `pan_eff` is 0, `dac_valid` is 0 and `pix_ready` is 1. Every register reads 0 and the phase flip-flop is in the index phase.
- R2: The shared port alternates between two phases. A write in the index phase stores `cpu_wdata[4:0]` as the index and moves to the data phase. A write in the data phase updates the indexed register and moves back to the index phase. `cpu_rdata` always shows the register at the stored index.
- R3: When `stat_rd` is high at a clock edge, the flip-flop returns to the index phase and any write in that same cycle is dropped.
- R4: The registers have these indices and widths:
  - Indices 0 to 15 are palette entries of 6 bits.
  - Index 16 is the 8-bit mode register. Bit 7 selects the 4-bit colour-select width (1) or the 2-bit width (0). Bit 6 selects pass-through. Bit 5 enables the panning override.
  - Index 17 is the 4-bit colour-select register.
  - Index 18 is the 4-bit panning register.
  - Unimplemented bits read as 0.
- R5: While the override is not active, `pan_eff` equals the panning register. A new panning value appears on `pan_eff` in the cycle after its data write.
- R6: When `lc_hit` is high while mode bit 5 is set, `pan_eff` reads 0 from the next cycle onward. This holds even if the panning register is rewritten in the meantime. When mode bit 5 is clear, `lc_hit` has no effect.
- R7: A `vsync` pulse ends the override, and `pan_eff` shows the programmed panning value again from the next cycle. If `vsync` and `lc_hit` occur in the same cycle, `vsync` wins.
- R8: In 4-bit mode (mode bits 7:6 = 10), the address is built from two parts. Colour-select bits 3:0 form address bits 7:4. Bits 3:0 of the palette entry indexed by `pix_attr[3:0]` form address bits 3:0.
- R9: In 2-bit mode (mode bits 7:6 = 00), the address is built from two parts. Colour-select bits 3:2 form address bits 7:6. The six bits of the indexed palette entry form address bits 5:0.
- R10: In pass-through mode (mode bit 6 = 1), the address equals `pix_attr` unchanged, whatever the value of bit 7.
- R11: An accepted pixel appears on `dac_addr` with `dac_valid` high one cycle after acceptance. `pix_ready` equals `!dac_valid || dac_ready`. During a stall the output is held stable.
- R12: The address is computed from the register contents at acceptance time. Register writes made while the address is held in the output stage do not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Shared index/data write strobe |
| cpu_wdata | input | 8 | Write data for index or register |
| cpu_rdata | output | 8 | Contents of the register at the stored index |
| stat_rd | input | 1 | Status-read strobe; returns the phase flip-flop to index |
| pix_valid | input | 1 | Pixel attribute valid |
| pix_ready | output | 1 | Mapper can accept a pixel |
| pix_attr | input | 8 | Per-pixel attribute |
| dac_valid | output | 1 | Colour-table address valid |
| dac_ready | input | 1 | Downstream accepts the address |
| dac_addr | output | 8 | Colour-table address |
| lc_hit | input | 1 | Line-compare match strobe |
| vsync | input | 1 | Vertical-sync strobe |
| pan_eff | output | 4 | Effective horizontal panning value |

## Verification
The hardest states to reach are those where the panning override interacts with other activity. One case is the panning register being rewritten while the override is active. Another is `lc_hit` and `vsync` arriving in the same cycle. A third is the flip-flop left mid-sequence in the data phase when a status read arrives. The bench reaches each of these through the write port and the strobe pins with exact cycle placement. It then reads the result only through `pan_eff` and the register readback. Stall behaviour is covered by holding `dac_ready` low across several register writes, so that a stale or recomputed address would show up on `dac_addr`.

// File: rtl/attr_lut_pkg.sv
package attr_lut_pkg;
  localparam int DW     = 8;
  localparam int PAL_N  = 16;
  localparam int PAL_W  = 6;
  localparam int PAN_W  = 4;
  localparam int CS_W   = 4;

  // mode register bit positions
  localparam int MB_CS4     = 7;
  localparam int MB_PASS    = 6;
  localparam int MB_PCOMPAT = 5;

  typedef enum logic {
    PH_INDEX = 1'b0,
    PH_DATA  = 1'b1
  } port_phase_e;
endpackage

// File: rtl/attr_lut_regs.sv
module attr_lut_regs
  import attr_lut_pkg::*;
#(
  parameter int W_DATA = DW,
  parameter int N_PAL  = PAL_N,
  parameter int W_PAL  = PAL_W,
  parameter int W_PAN  = PAN_W,
  parameter int W_CS   = CS_W,
  localparam int IDX_W  = $clog2(N_PAL + 3),
  localparam int PIDX_W = $clog2(N_PAL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [W_DATA-1:0] wdata,
  input  logic              stat_rd,
  output logic [W_DATA-1:0] rdata,
  output port_phase_e       phase,
  output logic [W_DATA-1:0] mode_q,
  output logic [W_CS-1:0]   csel_q,
  output logic [W_PAN-1:0]  pan_q,
  input  logic [PIDX_W-1:0] pal_ridx,
  output logic [W_PAL-1:0]  pal_rdata
);
  localparam logic [IDX_W-1:0] A_MODE = IDX_W'(N_PAL);
  localparam logic [IDX_W-1:0] A_CSEL = IDX_W'(N_PAL + 1);
  localparam logic [IDX_W-1:0] A_PAN  = IDX_W'(N_PAL + 2);

  logic [IDX_W-1:0] idx_q;
  logic [W_PAL-1:0] pal_q [N_PAL];
  logic             data_we;

  assign data_we = wr && !stat_rd && (phase == PH_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_INDEX;
      idx_q  <= '0;
      mode_q <= '0;
      csel_q <= '0;
      pan_q  <= '0;
    end else if (stat_rd) begin
      phase <= PH_INDEX;
    end else if (wr) begin
      if (phase == PH_INDEX) begin
        idx_q <= wdata[IDX_W-1:0];
        phase <= PH_DATA;
      end else begin
        phase <= PH_INDEX;
        if (idx_q == A_MODE) mode_q <= wdata;
        if (idx_q == A_CSEL) csel_q <= wdata[W_CS-1:0];
        if (idx_q == A_PAN)  pan_q  <= wdata[W_PAN-1:0];
      end
    end
  end

  for (genvar g = 0; g < N_PAL; g++) begin : g_pal
    always_ff @(posedge clk) begin
      if (!rst_n)
        pal_q[g] <= '0;
      else if (data_we && idx_q == IDX_W'(g))
        pal_q[g] <= wdata[W_PAL-1:0];
    end
  end

  assign pal_rdata = pal_q[pal_ridx];

  always_comb begin
    rdata = '0;
    if (idx_q < IDX_W'(N_PAL))
      rdata = W_DATA'(pal_q[idx_q[PIDX_W-1:0]]);
    else if (idx_q == A_MODE)
      rdata = mode_q;
    else if (idx_q == A_CSEL)
      rdata = W_DATA'(csel_q);
    else if (idx_q == A_PAN)
      rdata = W_DATA'(pan_q);
  end
endmodule

// File: rtl/attr_lut_pan.sv
module attr_lut_pan #(
  parameter int W_PAN = attr_lut_pkg::PAN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lc_hit,
  input  logic             vsync,
  input  logic             compat,
  input  logic [W_PAN-1:0] pan_q,
  output logic [W_PAN-1:0] pan_eff
);
  logic forced_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      forced_q <= 1'b0;
    else if (vsync)
      forced_q <= 1'b0;
    else if (lc_hit && compat)
      forced_q <= 1'b1;
  end

  assign pan_eff = forced_q ? '0 : pan_q;
endmodule

// File: rtl/attr_lut_map.sv
module attr_lut_map #(
  parameter int W_DATA = attr_lut_pkg::DW,
  parameter int W_PAL  = attr_lut_pkg::PAL_W,
  parameter int W_CS   = attr_lut_pkg::CS_W,
  localparam int LO4 = W_DATA - W_CS,
  localparam int LO2 = W_DATA - 2
) (
  input  logic [W_DATA-1:0] attr,
  input  logic              pass,
  input  logic              cs4,
  input  logic [W_CS-1:0]   csel,
  input  logic [W_PAL-1:0]  pal,
  output logic [W_DATA-1:0] addr
);
  always_comb begin
    if (pass)
      addr = attr;
    else if (cs4)
      addr = {csel, pal[LO4-1:0]};
    else
      addr = {csel[W_CS-1 -: 2], pal[LO2-1:0]};
  end
endmodule

// File: rtl/attr_lut_ostage.sv
module attr_lut_ostage #(
  parameter int W = attr_lut_pkg::DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/attr_lut_path.sv
module attr_lut_path
  import attr_lut_pkg::*;
#(
  parameter int W_DATA = DW,
  parameter int N_PAL  = PAL_N,
  parameter int W_PAL  = PAL_W,
  parameter int W_PAN  = PAN_W,
  parameter int W_CS   = CS_W,
  localparam int PIDX_W = $clog2(N_PAL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [W_DATA-1:0] cpu_wdata,
  output logic [W_DATA-1:0] cpu_rdata,
  input  logic              stat_rd,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [W_DATA-1:0] pix_attr,
  output logic              dac_valid,
  input  logic              dac_ready,
  output logic [W_DATA-1:0] dac_addr,
  input  logic              lc_hit,
  input  logic              vsync,
  output logic [W_PAN-1:0]  pan_eff
);
  port_phase_e       port_phase;
  logic [W_DATA-1:0] mode_q;
  logic [W_CS-1:0]   csel_q;
  logic [W_PAN-1:0]  pan_q;
  logic [W_PAL-1:0]  pal_entry;
  logic [W_DATA-1:0] map_addr;

  attr_lut_regs #(
    .W_DATA(W_DATA), .N_PAL(N_PAL), .W_PAL(W_PAL), .W_PAN(W_PAN), .W_CS(W_CS)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (cpu_wr),
    .wdata    (cpu_wdata),
    .stat_rd  (stat_rd),
    .rdata    (cpu_rdata),
    .phase    (port_phase),
    .mode_q   (mode_q),
    .csel_q   (csel_q),
    .pan_q    (pan_q),
    .pal_ridx (pix_attr[PIDX_W-1:0]),
    .pal_rdata(pal_entry)
  );

  attr_lut_pan #(.W_PAN(W_PAN)) u_pan (
    .clk    (clk),
    .rst_n  (rst_n),
    .lc_hit (lc_hit),
    .vsync  (vsync),
    .compat (mode_q[MB_PCOMPAT]),
    .pan_q  (pan_q),
    .pan_eff(pan_eff)
  );

  attr_lut_map #(.W_DATA(W_DATA), .W_PAL(W_PAL), .W_CS(W_CS)) u_map (
    .attr(pix_attr),
    .pass(mode_q[MB_PASS]),
    .cs4 (mode_q[MB_CS4]),
    .csel(csel_q),
    .pal (pal_entry),
    .addr(map_addr)
  );

  attr_lut_ostage #(.W(W_DATA)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (pix_valid),
    .in_ready (pix_ready),
    .in_data  (map_addr),
    .out_valid(dac_valid),
    .out_ready(dac_ready),
    .out_data (dac_addr)
  );
endmodule

// File: rtl/attr_lut_path_chk.sv
module attr_lut_path_chk #(
  parameter int W_DATA = 8,
  parameter int W_PAN  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_wr,
  input logic              stat_rd,
  input logic              phase,
  input logic [W_DATA-1:0] mode_q,
  input logic [W_PAN-1:0]  pan_q,
  input logic              lc_hit,
  input logic              vsync,
  input logic [W_PAN-1:0]  pan_eff,
  input logic              pix_valid,
  input logic              pix_ready,
  input logic [W_DATA-1:0] pix_attr,
  input logic              dac_valid,
  input logic              dac_ready,
  input logic [W_DATA-1:0] dac_addr
);
  // R2
  phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !stat_rd) |=> (phase != $past(phase)));

  // R3
  stat_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (phase == 1'b0));

  // R6
  lc_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lc_hit && mode_q[5] && !vsync) |=> (pan_eff == '0));

  // R7
  vsync_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> (pan_eff == pan_q));

  // R10
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready && mode_q[6]) |=> (dac_valid && dac_addr == $past(pix_attr)));

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_valid && !dac_ready) |=> (dac_valid && $stable(dac_addr)));
endmodule

bind attr_lut_path attr_lut_path_chk #(.W_DATA(W_DATA), .W_PAN(W_PAN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_wr   (cpu_wr),
  .stat_rd  (stat_rd),
  .phase    (port_phase),
  .mode_q   (mode_q),
  .pan_q    (pan_q),
  .lc_hit   (lc_hit),
  .vsync    (vsync),
  .pan_eff  (pan_eff),
  .pix_valid(pix_valid),
  .pix_ready(pix_ready),
  .pix_attr (pix_attr),
  .dac_valid(dac_valid),
  .dac_ready(dac_ready),
  .dac_addr (dac_addr)
);

// File: tb/attr_lut_path_test.sv
`timescale 1ns/1ps
module attr_lut_path_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       stat_rd = 1'b0;
  logic       pix_valid = 1'b0;
  logic       pix_ready;
  logic [7:0] pix_attr = '0;
  logic       dac_valid;
  logic       dac_ready = 1'b1;
  logic [7:0] dac_addr;
  logic       lc_hit = 1'b0;
  logic       vsync = 1'b0;
  logic [3:0] pan_eff;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  attr_lut_path uut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .stat_rd(stat_rd), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_attr(pix_attr), .dac_valid(dac_valid),
    .dac_ready(dac_ready), .dac_addr(dac_addr), .lc_hit(lc_hit),
    .vsync(vsync), .pan_eff(pan_eff)
  );

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_byte(logic [7:0] b);
    @(negedge clk); cpu_wr = 1'b1; cpu_wdata = b;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic pulse_stat();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic set_reg(logic [7:0] i, logic [7:0] v);
    pulse_stat(); wr_byte(i); wr_byte(v);
  endtask

  task automatic get_reg(logic [7:0] i, output logic [7:0] v);
    pulse_stat(); wr_byte(i); v = cpu_rdata;
  endtask

  task automatic send_pix(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); pix_valid = 1'b1; pix_attr = a; dac_ready = 1'b1;
    @(negedge clk); pix_valid = 1'b0;
    chk("R11 valid after accept", int'(dac_valid), 1);
    d = dac_addr;
  endtask

  task automatic pulse_lc_vs(logic l, logic v);
    @(negedge clk); lc_hit = l; vsync = v;
    @(negedge clk); lc_hit = 1'b0; vsync = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pan_eff", int'(pan_eff), 0);
    chk("R1 dac_valid", int'(dac_valid), 0);
    chk("R1 pix_ready", int'(pix_ready), 1);
    chk("R1 rdata", int'(cpu_rdata), 0);
  endtask

  task automatic t_port();
    logic [7:0] v;
    set_reg(8'd17, 8'hA5);
    get_reg(8'd17, v);
    chk("R4 csel width", int'(v), 8'h05);
    set_reg(8'd3, 8'hFF);
    get_reg(8'd3, v);
    chk("R4 palette width", int'(v), 8'h3F);
    set_reg(8'd16, 8'hE0);
    get_reg(8'd16, v);
    chk("R4 mode readback", int'(v), 8'hE0);
    set_reg(8'd16, 8'h00);
    pulse_stat(); wr_byte(8'd18); wr_byte(8'd2);
    wr_byte(8'd18); wr_byte(8'd6);
    chk("R2 alternation second pair", int'(pan_eff), 6);
    chk("R5 pan follows reg", int'(pan_eff), 6);
    pulse_stat(); wr_byte(8'd18); pulse_stat();
    wr_byte(8'd18); wr_byte(8'd7);
    chk("R3 status resets phase", int'(pan_eff), 7);
    @(negedge clk); stat_rd = 1'b1; cpu_wr = 1'b1; cpu_wdata = 8'd17;
    @(negedge clk); stat_rd = 1'b0; cpu_wr = 1'b0;
    wr_byte(8'd18); wr_byte(8'd1);
    chk("R3 write with status dropped", int'(pan_eff), 1);
  endtask

  task automatic t_map();
    logic [7:0] d;
    set_reg(8'd6, 8'h15);
    set_reg(8'd17, 8'h06);
    set_reg(8'd16, 8'h80);
    send_pix(8'h06, d); chk("R8 4-bit map", int'(d), 8'h65);
    send_pix(8'hF6, d); chk("R8 upper attr ignored", int'(d), 8'h65);
    set_reg(8'd16, 8'h00);
    send_pix(8'h06, d); chk("R9 2-bit map", int'(d), 8'h55);
    set_reg(8'd16, 8'h40);
    send_pix(8'h9E, d); chk("R10 pass-through", int'(d), 8'h9E);
    set_reg(8'd16, 8'hC0);
    send_pix(8'h3B, d); chk("R10 pass with cs4", int'(d), 8'h3B);
    @(negedge clk);
    chk("R11 valid drops", int'(dac_valid), 0);
  endtask

  task automatic t_pan();
    set_reg(8'd18, 8'd9);
    set_reg(8'd16, 8'h20);
    pulse_lc_vs(1'b1, 1'b0);
    chk("R6 forced zero", int'(pan_eff), 0);
    repeat (3) @(negedge clk);
    chk("R6 zero held", int'(pan_eff), 0);
    set_reg(8'd18, 8'd4);
    chk("R6 zero despite rewrite", int'(pan_eff), 0);
    pulse_lc_vs(1'b0, 1'b1);
    chk("R7 released", int'(pan_eff), 4);
    pulse_lc_vs(1'b1, 1'b1);
    chk("R7 vsync wins", int'(pan_eff), 4);
    set_reg(8'd16, 8'h00);
    pulse_lc_vs(1'b1, 1'b0);
    chk("R6 no compat no effect", int'(pan_eff), 4);
  endtask

  task automatic t_stall();
    set_reg(8'd16, 8'h40);
    @(negedge clk); dac_ready = 1'b0; pix_valid = 1'b1; pix_attr = 8'h11;
    @(negedge clk); pix_attr = 8'h22;
    chk("R11 first out", int'(dac_addr), 8'h11);
    chk("R11 ready low in stall", int'(pix_ready), 0);
    @(negedge clk);
    chk("R11 held", int'(dac_addr), 8'h11);
    dac_ready = 1'b1;
    @(negedge clk);
    chk("R11 next after release", int'(dac_addr), 8'h22);
    pix_valid = 1'b0;
    @(negedge clk);
    chk("R11 empty", int'(dac_valid), 0);
  endtask

  task automatic t_snapshot();
    set_reg(8'd16, 8'h80);
    set_reg(8'd17, 8'h06);
    @(negedge clk); dac_ready = 1'b0; pix_valid = 1'b1; pix_attr = 8'h06;
    @(negedge clk); pix_valid = 1'b0;
    set_reg(8'd17, 8'h0C);
    set_reg(8'd6, 8'h00);
    chk("R12 held across writes", int'(dac_addr), 8'h65);
    dac_ready = 1'b1;
    @(negedge clk);
    chk("R12 drained", int'(dac_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_port();
    t_map();
    t_pan();
    t_stall();
    t_snapshot();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog all act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule